// File: doc/BRIEF.md
# Character I/O and Interrupt Controller

This block sits between a simple byte-wide character device and an accumulator-based CPU. It keeps one receive holding register with an input-ready flag, and one transmit holding register with an output-ready flag. The device side offers a byte with a strobe on receive. On transmit, the block presents a byte with a valid signal, and the device acknowledges it once consumed.

On the CPU side, the control unit raises `exec` in the execute step of an input/output instruction. It passes the six instruction bits that select the operations in `io_bits`. The block answers in the same cycle with a request to clear the step counter, a request to load the accumulator's low byte, and a skip request. The flag and holding-register updates take effect at the following edge.

The block also holds the interrupt-enable flip-flop and the interrupt-cycle request flip-flop. The request is raised when interrupts are enabled and either flag is set, and only while the CPU is outside its first three instruction steps. The T2 step of the interrupt cycle clears both the request and the enable.

Top module: `chario_irq_ctl`

## Requirements
- R1: After reset the input-ready flag is 0, the output-ready flag is 1 (so `dev_out_vld` is 0), and `ien`, `irq_pending` and `overrun` are all 0.
- R2: A `dev_in_stb` pulse while the input-ready flag is 0 captures `dev_in_byte`. From the next cycle on, `in_char` shows that byte and the input-ready flag is 1.
- R3: A `dev_in_stb` pulse while the input-ready flag is 1 leaves `in_char` unchanged and sets `overrun`. `overrun` stays 1 until reset.
- R4: `io_bits[5]` (input-character) with `exec` raises `ac_load` in that same cycle, with `in_char` valid, and clears the input-ready flag at the next edge.
- R5: `io_bits[4]` (output-character) with `exec` copies `ac_lo` into `dev_out_byte` and clears the output-ready flag at the next edge, so `dev_out_vld` becomes 1.
- R6: `dev_out_ack` while `dev_out_vld` is 1 sets the output-ready flag at the next edge, so `dev_out_vld` returns to 0.
- R7: `skip_req` is 1 in an `exec` cycle exactly when either of these holds: `io_bits[3]` is set and the input-ready flag is 1, or `io_bits[2]` is set and the output-ready flag is 1. It is 0 whenever `exec` is 0.
- R8: `sc_clr` is 1 in every `exec` cycle and 0 otherwise.
- R9: `io_bits[1]` with `exec` sets `ien` at the next edge. `io_bits[0]` with `exec` clears it. `irq_t2` clears it, and clearing wins over setting.
- R10: `irq_pending` is set at an edge where `ien` is 1, at least one flag is 1 and `step_early` is 0. It is never set while `step_early` is 1 or while both flags are 0.
- R11: `irq_t2` clears `irq_pending` at the next edge. Disabling interrupts with `io_bits[0]` does not clear it.
- R12: A strobe that arrives while the input-ready flag is 1 is dropped, even in the same cycle as an input-character instruction that clears the flag. It sets `overrun`, and the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_in_byte | input | W | Byte from the device |
| dev_in_stb | input | 1 | Device byte strobe |
| dev_out_byte | output | W | Byte offered to the device |
| dev_out_vld | output | 1 | Byte offered and not yet consumed |
| dev_out_ack | input | 1 | Device consumed the byte |
| exec | input | 1 | Execute step of an I/O instruction |
| io_bits | input | 6 | Instruction bits 11..6: input, output, skip-in, skip-out, enable, disable |
| ac_lo | input | W | Accumulator low byte |
| step_early | input | 1 | CPU is in step T0, T1 or T2 |
| irq_t2 | input | 1 | T2 step of the interrupt cycle |
| in_char | output | W | Received byte for the accumulator |
| ac_load | output | 1 | Load accumulator low byte from in_char |
| skip_req | output | 1 | Request a PC increment |
| sc_clr | output | 1 | Clear the step counter |
| ien | output | 1 | Interrupt enable |
| irq_pending | output | 1 | Interrupt-cycle request |
| overrun | output | 1 | Sticky dropped-byte indicator |

## Verification
The bench sends a byte while the previous one is still unread. A design that overwrote the holding register would show the new byte on `in_char`, and one without the sticky bit would leave `overrun` low. It checks the input instruction and a strobe landing in the same cycle, where a wrong priority either keeps the flag set or silently keeps a byte. It holds interrupts enabled while `step_early` is high and while both flags are clear, and a design that ignored either gate would raise `irq_pending` too early. It also confirms that disabling interrupts leaves a pending request in place until the interrupt-cycle T2 step.

// File: rtl/chario_irq_ctl.sv
module chario_irq_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dev_in_byte,
  input  logic         dev_in_stb,
  output logic [W-1:0] dev_out_byte,
  output logic         dev_out_vld,
  input  logic         dev_out_ack,
  input  logic         exec,
  input  logic [5:0]   io_bits,
  input  logic [W-1:0] ac_lo,
  input  logic         step_early,
  input  logic         irq_t2,
  output logic [W-1:0] in_char,
  output logic         ac_load,
  output logic         skip_req,
  output logic         sc_clr,
  output logic         ien,
  output logic         irq_pending,
  output logic         overrun
);

  logic [W-1:0] rx_hold, tx_hold;
  logic rx_full, tx_free, irq_en, req_ff, ovr;

  wire do_inp = exec & io_bits[5];
  wire do_out = exec & io_bits[4];
  wire do_ski = exec & io_bits[3];
  wire do_sko = exec & io_bits[2];
  wire do_ion = exec & io_bits[1];
  wire do_iof = exec & io_bits[0];
  wire accept = dev_in_stb & ~rx_full;
  wire drop   = dev_in_stb & rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (accept) rx_hold <= dev_in_byte;
      if (accept) rx_full <= 1'b1;
      else if (do_inp) rx_full <= 1'b0;
      if (drop) ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hold <= '0;
      tx_free <= 1'b1;
    end else if (do_out) begin
      tx_hold <= ac_lo;
      tx_free <= 1'b0;
    end else if (dev_out_ack && !tx_free) begin
      tx_free <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      req_ff <= 1'b0;
    end else begin
      if (irq_t2 || do_iof) irq_en <= 1'b0;
      else if (do_ion) irq_en <= 1'b1;
      if (irq_t2) req_ff <= 1'b0;
      else if (irq_en && (rx_full || tx_free) && !step_early) req_ff <= 1'b1;
    end
  end

  assign in_char      = rx_hold;
  assign dev_out_byte = tx_hold;
  assign dev_out_vld  = ~tx_free;
  assign ac_load      = do_inp;
  assign skip_req     = (do_ski & rx_full) | (do_sko & tx_free);
  assign sc_clr       = exec;
  assign ien          = irq_en;
  assign irq_pending  = req_ff;
  assign overrun      = ovr;

endmodule

// File: rtl/chario_irq_chk.sv
module chario_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dev_out_vld,
  input logic [W-1:0] dev_out_byte,
  input logic         dev_out_ack,
  input logic         exec,
  input logic [5:0]   io_bits,
  input logic [W-1:0] ac_lo,
  input logic         step_early,
  input logic         irq_t2,
  input logic         skip_req,
  input logic         ien,
  input logic         irq_pending,
  input logic         overrun
);

  p_out_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && io_bits[4]) |=> (dev_out_vld && dev_out_byte == $past(ac_lo)));

  p_ack_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_vld && dev_out_ack && !(exec && io_bits[4])) |=> !dev_out_vld);

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_ion_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && io_bits[1] && !io_bits[0] && !irq_t2) |=> ien);

  p_t2_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t2 |=> (!irq_pending && !ien));

  p_early_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && step_early) |=> !irq_pending);

  p_skip_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> exec);

endmodule

bind chario_irq_ctl chario_irq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_out_vld(dev_out_vld), .dev_out_byte(dev_out_byte),
  .dev_out_ack(dev_out_ack), .exec(exec), .io_bits(io_bits), .ac_lo(ac_lo),
  .step_early(step_early), .irq_t2(irq_t2), .skip_req(skip_req), .ien(ien),
  .irq_pending(irq_pending), .overrun(overrun)
);

// File: tb/sim_chario_irq_ctl.sv
`timescale 1ns/1ps
module sim_chario_irq_ctl;
  localparam int W = 8;
  localparam int SEL_IN = 0, SEL_OB = 1, SEL_OV = 2, SEL_SK = 3, SEL_AL = 4,
                 SEL_SC = 5, SEL_IE = 6, SEL_IP = 7, SEL_OR = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] dev_in_byte = '0, ac_lo = '0;
  logic dev_in_stb = 0, dev_out_ack = 0, exec = 0, step_early = 0, irq_t2 = 0;
  logic [5:0] io_bits = '0;
  logic [W-1:0] dev_out_byte, in_char;
  logic dev_out_vld, ac_load, skip_req, sc_clr, ien, irq_pending, overrun;

  typedef struct { int sel; int exp; string req; } item_t;
  item_t sb[$];
  int vectors = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chario_irq_ctl #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_in_byte(dev_in_byte), .dev_in_stb(dev_in_stb),
    .dev_out_byte(dev_out_byte), .dev_out_vld(dev_out_vld), .dev_out_ack(dev_out_ack),
    .exec(exec), .io_bits(io_bits), .ac_lo(ac_lo), .step_early(step_early),
    .irq_t2(irq_t2), .in_char(in_char), .ac_load(ac_load), .skip_req(skip_req),
    .sc_clr(sc_clr), .ien(ien), .irq_pending(irq_pending), .overrun(overrun)
  );

  function automatic int observe(int sel);
    case (sel)
      SEL_IN: return int'(in_char);
      SEL_OB: return int'(dev_out_byte);
      SEL_OV: return int'(dev_out_vld);
      SEL_SK: return int'(skip_req);
      SEL_AL: return int'(ac_load);
      SEL_SC: return int'(sc_clr);
      SEL_IE: return int'(ien);
      SEL_IP: return int'(irq_pending);
      default: return int'(overrun);
    endcase
  endfunction

  task automatic expect_item(int sel, int exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic instr(logic [5:0] bits);
    exec = 1; io_bits = bits;
  endtask

  task automatic idle();
    exec = 0; io_bits = '0; dev_in_stb = 0; dev_out_ack = 0; irq_t2 = 0;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      act = observe(it.sel);
      vectors++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    expect_item(SEL_OV, 0, "R1"); expect_item(SEL_IE, 0, "R1");
    expect_item(SEL_IP, 0, "R1"); expect_item(SEL_OR, 0, "R1");
    instr(6'b001000); expect_item(SEL_SK, 0, "R1"); expect_item(SEL_SC, 1, "R8");
    tick();
    instr(6'b000100); expect_item(SEL_SK, 1, "R7");
    tick();
    idle(); io_bits = 6'b001100; expect_item(SEL_SK, 0, "R7"); expect_item(SEL_SC, 0, "R8");
    tick(); idle();

    dev_in_byte = 8'hA5; dev_in_stb = 1; tick(); idle();
    expect_item(SEL_IN, 8'hA5, "R2");
    instr(6'b001000); expect_item(SEL_SK, 1, "R2"); tick(); idle();

    dev_in_byte = 8'h3C; dev_in_stb = 1; tick(); idle();
    expect_item(SEL_IN, 8'hA5, "R3"); expect_item(SEL_OR, 1, "R3");

    instr(6'b100000); expect_item(SEL_AL, 1, "R4"); expect_item(SEL_IN, 8'hA5, "R4");
    tick(); idle();
    expect_item(SEL_AL, 0, "R4");
    instr(6'b001000); expect_item(SEL_SK, 0, "R4"); tick(); idle();
    expect_item(SEL_OR, 1, "R3");

    dev_in_byte = 8'h5A; dev_in_stb = 1; tick(); idle();
    expect_item(SEL_IN, 8'h5A, "R2");
    instr(6'b100000); dev_in_byte = 8'h77; dev_in_stb = 1; tick(); idle();
    expect_item(SEL_IN, 8'h5A, "R12");
    instr(6'b001000); expect_item(SEL_SK, 0, "R12"); tick(); idle();

    ac_lo = 8'hC3; instr(6'b010000); tick(); idle();
    expect_item(SEL_OB, 8'hC3, "R5"); expect_item(SEL_OV, 1, "R5");
    instr(6'b000100); expect_item(SEL_SK, 0, "R7"); tick(); idle();
    dev_out_ack = 1; tick(); idle();
    expect_item(SEL_OV, 0, "R6"); expect_item(SEL_OB, 8'hC3, "R6");
    instr(6'b000100); expect_item(SEL_SK, 1, "R6"); tick(); idle();

    step_early = 1; instr(6'b000010); tick(); idle();
    expect_item(SEL_IE, 1, "R9"); expect_item(SEL_IP, 0, "R10");
    tick(); expect_item(SEL_IP, 0, "R10");
    step_early = 0; tick(); expect_item(SEL_IP, 1, "R10");
    irq_t2 = 1; tick(); idle();
    expect_item(SEL_IP, 0, "R11"); expect_item(SEL_IE, 0, "R9");

    ac_lo = 8'h11; instr(6'b010000); tick(); idle();
    instr(6'b000010); tick(); idle();
    expect_item(SEL_IE, 1, "R9");
    tick(); expect_item(SEL_IP, 0, "R10");
    dev_out_ack = 1; tick(); idle();
    tick(); expect_item(SEL_IP, 1, "R10");
    instr(6'b000001); tick(); idle();
    expect_item(SEL_IE, 0, "R9"); expect_item(SEL_IP, 1, "R11");
    irq_t2 = 1; instr(6'b000010); tick(); idle();
    expect_item(SEL_IP, 0, "R11"); expect_item(SEL_IE, 0, "R9");

    rst_n = 0; tick(); rst_n = 1;
    expect_item(SEL_OR, 0, "R3"); expect_item(SEL_OV, 0, "R1");
    tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule